// File: doc/BRIEF.md
# Fully Associative Read Cache with First-In First-Out Replacement

This block sits between a processor read port and a slower main memory. It keeps a small set of entries, and each entry holds a full address together with the data word stored at that address. Because every entry holds the complete address as its tag, any address can be placed in any slot. On a read, the incoming address is compared against every valid entry at the same time. A match returns the stored word one cycle after the request is accepted.

When no entry matches, the cache starts a main-memory read over a request/acknowledge handshake. It writes the returned word into a victim slot and forwards the word to the processor. The victim is picked by a circular pointer that moves on by one after every insertion. Empty slots therefore fill in order, and once the cache is full the oldest insertion is the one that gets overwritten.

A synchronous initialize input empties the cache and clears two reference counters, one for hits and one for misses. Software outside the block can compute the hit ratio from these counters.

Top module: `assoc_fifo_cache`

## Requirements
- R1: After reset, `cpu_ready` is high, `mem_req` and `cpu_rvalid` are low, and both counters read zero.
- R2: A read accepted while `cpu_ready` is high, whose address matches a valid entry, gives `cpu_rvalid`=1, `cpu_hit`=1 and the stored word on `cpu_rdata` in the next cycle, and does not raise `mem_req`.
- R3: A read that matches no valid entry raises `mem_req` in the next cycle with `mem_addr` equal to the requested address. `mem_req` stays high until a cycle in which `mem_ack` is high.
- R4: In the cycle after `mem_ack`, the cache drops `mem_req` and shows `cpu_rvalid`=1, `cpu_hit`=0 and the word sampled from `mem_rdata` on `cpu_rdata`. The fetched pair is stored, so a later read of the same address hits.
- R5: Each insertion goes into the slot named by the round-robin pointer. When all slots are valid, a new miss therefore overwrites the entry that was inserted earliest, and the other entries stay valid.
- R6: The pointer starts at slot 0 and moves on by one after every insertion, wrapping modulo the entry count. The next round of evictions therefore repeats the insertion order.
- R7: `hit_count` rises by one for each completed hit and `miss_count` rises by one for each completed miss. Neither changes at any other time.
- R8: A cycle with `init` high clears every valid bit, both counters and the pointer, and drops any pending `mem_req`. A previously cached address then misses.
- R9: While a miss is outstanding, `cpu_ready` is low and `cpu_req` is ignored: `mem_addr` keeps the original address and only one reference is counted.
- R10: `cpu_rvalid` is high for one cycle per completed reference. It is high only in the cycle after a hit was accepted, or in the cycle after `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Synchronous empty-and-clear command |
| cpu_req | input | 1 | Processor read request, taken when `cpu_ready` is high |
| cpu_addr | input | ADDR_W (15) | Processor read address |
| cpu_ready | output | 1 | Cache idle and able to take a request |
| cpu_rvalid | output | 1 | One-cycle pulse: `cpu_rdata` is valid |
| cpu_hit | output | 1 | Qualifies `cpu_rvalid`: 1 if the word came from the cache |
| cpu_rdata | output | DATA_W (12) | Read data to the processor |
| mem_req | output | 1 | Main-memory read request, held until acknowledged |
| mem_addr | output | ADDR_W (15) | Main-memory read address |
| mem_ack | input | 1 | Main memory has put the word on `mem_rdata` |
| mem_rdata | input | DATA_W (12) | Word returned by main memory |
| hit_count | output | CNT_W (16) | Number of completed hits |
| miss_count | output | CNT_W (16) | Number of completed misses |

## Verification
The first directed pattern fills every slot with distinct addresses, including the all-zeros and all-ones addresses, and then reads them all back. Misses during the fill and hits on the read-back separate correct tag compare and valid gating from a cache that never hits or always hits. Further misses after the cache is full, interleaved with re-reads, show whether the victim is the oldest insertion and whether the pointer wraps, which LRU or random replacement would not match. Random reads from an address pool slightly larger than the cache, with random acknowledge delays, mix hits, evictions and counter updates. A request injected during a fetch and an initialize pulse show that ignored input and clearing behave correctly.

// File: rtl/cache_pkg.sv
package cache_pkg;

   typedef enum logic [0:0] {
      ST_IDLE  = 1'b0,
      ST_FETCH = 1'b1
   } ctrl_state_t;

endpackage

// File: rtl/cache_entry_store.sv
module cache_entry_store #(
   parameter int ADDR_W  = 15,
   parameter int DATA_W  = 12,
   parameter int ENTRIES = 8,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_tag,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [ADDR_W-1:0] tags   [ENTRIES],
   output logic [ENTRIES-1:0] valids,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] words [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valids[g] <= 1'b0;
         end else if (clear) begin
            valids[g] <= 1'b0;
         end else if (sel) begin
            valids[g] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (sel && !clear) begin
            tags[g]  <= wr_tag;
            words[g] <= wr_data;
         end
      end
   end

   assign rd_data = words[rd_idx];

endmodule

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
   parameter int ADDR_W     = 15,
   parameter int ENTRIES    = 8,
   parameter bit ONEHOT_ENC = 1'b1,
   localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic [ADDR_W-1:0]  lookup_addr,
   input  logic [ADDR_W-1:0]  tags   [ENTRIES],
   input  logic [ENTRIES-1:0] valids,
   output logic [ENTRIES-1:0] match_vec,
   output logic               any_hit,
   output logic [IDX_W-1:0]   hit_idx
);

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match_vec[g] = valids[g] && (tags[g] == lookup_addr);
   end

   assign any_hit = |match_vec;

   if (ONEHOT_ENC) begin : g_or_enc
      always_comb begin
         hit_idx = '0;
         for (int i = 0; i < ENTRIES; i++) begin
            hit_idx = hit_idx | (IDX_W'(i) & {IDX_W{match_vec[i]}});
         end
      end
   end else begin : g_prio_enc
      always_comb begin
         hit_idx = '0;
         for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/cache_fifo_ptr.sv
module cache_fifo_ptr #(
   parameter int ENTRIES = 8,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             advance,
   output logic [IDX_W-1:0] ptr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (clear) begin
         ptr <= '0;
      end else if (advance) begin
         ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
      end
   end

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
   import cache_pkg::*;
#(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 12,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              cpu_req,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              any_hit,
   input  logic [DATA_W-1:0] hit_data,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              cpu_ready,
   output logic              cpu_rvalid,
   output logic              cpu_hit,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              fill_en,
   output logic [CNT_W-1:0]  hit_count,
   output logic [CNT_W-1:0]  miss_count
);

   ctrl_state_t state;

   assign cpu_ready = (state == ST_IDLE);
   assign fill_en   = (state == ST_FETCH) && mem_ack && !init;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cpu_rvalid <= 1'b0;
         cpu_hit    <= 1'b0;
         cpu_rdata  <= '0;
         mem_req    <= 1'b0;
         mem_addr   <= '0;
         hit_count  <= '0;
         miss_count <= '0;
      end else if (init) begin
         state      <= ST_IDLE;
         cpu_rvalid <= 1'b0;
         cpu_hit    <= 1'b0;
         mem_req    <= 1'b0;
         hit_count  <= '0;
         miss_count <= '0;
      end else begin
         cpu_rvalid <= 1'b0;
         cpu_hit    <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (cpu_req) begin
                  if (any_hit) begin
                     cpu_rvalid <= 1'b1;
                     cpu_hit    <= 1'b1;
                     cpu_rdata  <= hit_data;
                     hit_count  <= hit_count + 1'b1;
                  end else begin
                     state    <= ST_FETCH;
                     mem_req  <= 1'b1;
                     mem_addr <= cpu_addr;
                  end
               end
            end
            ST_FETCH: begin
               if (mem_ack) begin
                  state      <= ST_IDLE;
                  mem_req    <= 1'b0;
                  cpu_rvalid <= 1'b1;
                  cpu_rdata  <= mem_rdata;
                  miss_count <= miss_count + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/assoc_fifo_cache.sv
module assoc_fifo_cache #(
   parameter int ADDR_W     = 15,
   parameter int DATA_W     = 12,
   parameter int ENTRIES    = 8,
   parameter int CNT_W      = 16,
   parameter bit ONEHOT_ENC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              cpu_req,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              cpu_ready,
   output logic              cpu_rvalid,
   output logic              cpu_hit,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [CNT_W-1:0]  hit_count,
   output logic [CNT_W-1:0]  miss_count
);

   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2 || ENTRIES > 64) begin : g_bad_entries
      $error("assoc_fifo_cache: ENTRIES must lie in 2..64");
   end
   if (ADDR_W < 1 || DATA_W < 1 || CNT_W < 1) begin : g_bad_width
      $error("assoc_fifo_cache: widths must be positive");
   end

   logic [ADDR_W-1:0]  tags [ENTRIES];
   logic [ENTRIES-1:0] valids;
   logic [ENTRIES-1:0] match_vec;
   logic               any_hit;
   logic [IDX_W-1:0]   hit_idx;
   logic [IDX_W-1:0]   victim_ptr;
   logic [DATA_W-1:0]  hit_data;
   logic               fill_en;

   cache_tag_match #(
      .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .ONEHOT_ENC(ONEHOT_ENC)
   ) match_i (
      .lookup_addr(cpu_addr),
      .tags       (tags),
      .valids     (valids),
      .match_vec  (match_vec),
      .any_hit    (any_hit),
      .hit_idx    (hit_idx)
   );

   cache_entry_store #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES)
   ) store_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (init),
      .wr_en  (fill_en),
      .wr_idx (victim_ptr),
      .wr_tag (mem_addr),
      .wr_data(mem_rdata),
      .rd_idx (hit_idx),
      .tags   (tags),
      .valids (valids),
      .rd_data(hit_data)
   );

   cache_fifo_ptr #(
      .ENTRIES(ENTRIES)
   ) ptr_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (init),
      .advance(fill_en),
      .ptr    (victim_ptr)
   );

   cache_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
   ) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .init      (init),
      .cpu_req   (cpu_req),
      .cpu_addr  (cpu_addr),
      .any_hit   (any_hit),
      .hit_data  (hit_data),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .cpu_ready (cpu_ready),
      .cpu_rvalid(cpu_rvalid),
      .cpu_hit   (cpu_hit),
      .cpu_rdata (cpu_rdata),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .fill_en   (fill_en),
      .hit_count (hit_count),
      .miss_count(miss_count)
   );

endmodule

// File: rtl/assoc_fifo_cache_chk.sv
module assoc_fifo_cache_chk #(
   parameter int ENTRIES = 8,
   parameter int CNT_W   = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               init,
   input logic               cpu_req,
   input logic               cpu_ready,
   input logic               cpu_rvalid,
   input logic               cpu_hit,
   input logic               mem_req,
   input logic               mem_ack,
   input logic [CNT_W-1:0]   hit_count,
   input logic [CNT_W-1:0]   miss_count,
   input logic [ENTRIES-1:0] match_vec
);

   // R2: a hit never involves main memory
   assert_hit_no_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rvalid && cpu_hit) |-> !mem_req);

   // R3: request held until acknowledged
   assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n || init)
      (mem_req && !mem_ack) |=> mem_req);

   // R4: acknowledge ends the request and returns data
   assert_ack_ends_req_R4: assert property (@(posedge clk) disable iff (!rst_n || init)
      (mem_req && mem_ack) |=> (!mem_req && cpu_rvalid && !cpu_hit));

   // R5: a full address tag never matches two slots
   assert_single_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec));

   // R7: counters step by at most one
   assert_hit_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !init |=> (hit_count == $past(hit_count) || hit_count == $past(hit_count) + 1'b1));
   assert_miss_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !init |=> (miss_count == $past(miss_count) || miss_count == $past(miss_count) + 1'b1));

   // R10: data valid only after an accepted hit or an acknowledge
   assert_rvalid_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rvalid |-> ($past(cpu_req && cpu_ready) || $past(mem_req && mem_ack)));

endmodule

bind assoc_fifo_cache assoc_fifo_cache_chk #(
   .ENTRIES(ENTRIES), .CNT_W(CNT_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .init      (init),
   .cpu_req   (cpu_req),
   .cpu_ready (cpu_ready),
   .cpu_rvalid(cpu_rvalid),
   .cpu_hit   (cpu_hit),
   .mem_req   (mem_req),
   .mem_ack   (mem_ack),
   .hit_count (hit_count),
   .miss_count(miss_count),
   .match_vec (match_vec)
);

// File: tb/assoc_fifo_cache_tb_top.sv
`timescale 1ns/1ps
module assoc_fifo_cache_tb_top;

   localparam int AW = 15;
   localparam int DW = 12;
   localparam int NE = 8;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          init = 1'b0;
   logic          cpu_req = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic          cpu_ready, cpu_rvalid, cpu_hit;
   logic [DW-1:0] cpu_rdata;
   logic          mem_req;
   logic [AW-1:0] mem_addr;
   logic          mem_ack = 1'b0;
   logic [DW-1:0] mem_rdata = '0;
   logic [CW-1:0] hit_count, miss_count;

   always #4 clk = ~clk;

   assoc_fifo_cache #(.ADDR_W(AW), .DATA_W(DW), .ENTRIES(NE), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .init(init), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
      .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_hit(cpu_hit),
      .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .hit_count(hit_count), .miss_count(miss_count)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [AW-1:0] m_tag [NE];
   logic [NE-1:0] m_val;
   int            m_ptr;
   int            exp_hits, exp_misses;

   function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
      return DW'((a * 13) + 27 + (a >> 5));
   endfunction

   function automatic int m_find(input logic [AW-1:0] a);
      for (int i = 0; i < NE; i++) if (m_val[i] && m_tag[i] == a) return i;
      return -1;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_clear();
      m_val = '0;
      m_ptr = 0;
      exp_hits = 0;
      exp_misses = 0;
   endtask

   task automatic do_read(input logic [AW-1:0] a, input string req, input bit inject);
      int idx;
      int waits;
      @(negedge clk);
      check(cpu_ready == 1'b1, "R9 ready before issue", cpu_ready, 1);
      idx = m_find(a);
      cpu_req = 1'b1;
      cpu_addr = a;
      @(negedge clk);
      cpu_req = 1'b0;
      if (idx >= 0) begin
         check(cpu_rvalid && cpu_hit, {req, " R2 hit flags"}, {cpu_rvalid, cpu_hit}, 3);
         check(cpu_rdata == mem_word(a), {req, " R2 hit data"}, cpu_rdata, mem_word(a));
         check(!mem_req, "R2 no mem_req on hit", mem_req, 0);
         exp_hits++;
      end else begin
         check(mem_req && mem_addr == a, {req, " R3 miss request"}, mem_addr, a);
         check(!cpu_rvalid, "R3 no data before ack", cpu_rvalid, 0);
         if (inject) begin
            cpu_req = 1'b1;
            cpu_addr = a ^ 15'h0155;
            @(negedge clk);
            cpu_req = 1'b0;
            check(mem_req && mem_addr == a && !cpu_rvalid, "R9 ignored request",
                  mem_addr, a);
         end
         waits = $urandom_range(0, 3);
         for (int w = 0; w < waits; w++) begin
            @(negedge clk);
            check(mem_req == 1'b1, "R3 mem_req held", mem_req, 1);
         end
         mem_ack = 1'b1;
         mem_rdata = mem_word(a);
         @(negedge clk);
         mem_ack = 1'b0;
         mem_rdata = '0;
         check(cpu_rvalid && !cpu_hit && !mem_req, {req, " R4 fill flags"},
               {cpu_rvalid, cpu_hit, mem_req}, 4);
         check(cpu_rdata == mem_word(a), {req, " R4 fill data"}, cpu_rdata, mem_word(a));
         m_tag[m_ptr] = a;
         m_val[m_ptr] = 1'b1;
         m_ptr = (m_ptr + 1) % NE;
         exp_misses++;
      end
      @(negedge clk);
      check(!cpu_rvalid, "R10 single-cycle rvalid", cpu_rvalid, 0);
   endtask

   task automatic check_counts(input string tag);
      check(hit_count == CW'(exp_hits), {tag, " R7 hit_count"}, hit_count, exp_hits);
      check(miss_count == CW'(exp_misses), {tag, " R7 miss_count"}, miss_count, exp_misses);
   endtask

   logic [AW-1:0] dir_addr [NE+1];

   initial begin
      void'($urandom(32'h5eed_c0de));
      model_clear();
      dir_addr[0] = 15'h0000;
      dir_addr[1] = 15'h7FFF;
      for (int i = 2; i <= NE; i++) dir_addr[i] = AW'(15'h0100 * i + 3);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(cpu_ready && !mem_req && !cpu_rvalid, "R1 reset flags",
            {cpu_ready, mem_req, cpu_rvalid}, 4);
      check_counts("R1");

      // fill all slots, then read back
      for (int i = 0; i < NE; i++) do_read(dir_addr[i], "R6 fill", 1'b0);
      for (int i = 0; i < NE; i++) do_read(dir_addr[i], "R2 readback", 1'b0);
      check_counts("R7 after fill");

      // full cache: oldest is evicted
      do_read(dir_addr[NE], "R5 evict oldest", 1'b0);
      check(m_find(dir_addr[0]) < 0, "R5 model", 0, 0);
      do_read(dir_addr[1], "R5 survivor hits", 1'b0);
      do_read(dir_addr[0], "R5 evicted misses", 1'b0);
      do_read(dir_addr[1], "R6 second victim", 1'b0);
      for (int i = 0; i < NE; i++) do_read(AW'(15'h2000 + i), "R6 wrap round", 1'b0);
      do_read(15'h2000, "R6 wrapped hit", 1'b0);

      // ignored request during fetch
      do_read(15'h3333, "R9 inject", 1'b1);
      check_counts("R9 single count");

      // initialize
      @(negedge clk);
      init = 1'b1;
      @(negedge clk);
      init = 1'b0;
      model_clear();
      check_counts("R8 cleared");
      check(cpu_ready && !mem_req, "R8 idle after init", {cpu_ready, mem_req}, 2);
      do_read(15'h2001, "R8 miss after init", 1'b0);
      do_read(15'h2001, "R8 refill hits", 1'b0);

      // random mix
      for (int n = 0; n < 400; n++) begin
         logic [AW-1:0] a;
         a = AW'(15'h0400 + $urandom_range(0, NE + 3) * 15'h0011);
         do_read(a, "R5 random", ($urandom_range(0, 15) == 0));
      end
      check_counts("R7 final");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int c = 0; c < 150000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule